// File: doc/BRIEF.md
# Word-Interleaved Cluster Cache Slice

This block is the share of a level-one data cache that belongs to one cluster of a four-cluster statically scheduled processor. Each 32-byte cache block is dealt out one 4-byte word at a time across the four clusters. Word k of a block lives in the module of cluster k mod 4, so every cluster keeps a 2-word subblock of each block under its own tag. The local functional units issue loads and stores to the slice over a valid/ready request port. The slice decodes the home cluster of the address from address bits [3:2] and checks two places for the data: the local direct-mapped module (64 sets), and a 4-entry side buffer that keeps copies of subblocks owned by other clusters.

A hit in either place returns data one cycle after the request is accepted, and nothing is transferred between clusters. A local miss goes out through a refill port. A remote access that misses the side buffer goes out through a remote port, and the returned subblock is captured in the side buffer. Repeated remote reads of that subblock then complete inside the cluster. A remote store is always forwarded, and it removes the matching buffered copy.

Top module: `ilc_slice`

## Requirements
- R1: After reset the slice is empty: `req_ready` is 1, `rsp_valid`, `rem_req_valid` and `fill_req_valid` are 0, no local set is valid and the side buffer holds nothing.
- R2: The home cluster of an address is `addr[3:2]`. The word index within the 8-word block is `addr[4:2]`. The slice serves from its own module only the addresses whose home equals `CLUSTER_ID`, and it sends every other address towards the remote port.
- R3: A load accepted while the local module holds a matching tag at set `addr[10:5]` gives `rsp_valid` exactly one cycle later. The response carries code 2'b00 and the addressed word. Response codes are: 2'b00 local hit, 2'b01 side-buffer hit, 2'b10 remote access or miss.
- R4: On a local miss, `fill_req_valid` pulses one cycle after acceptance. The pulse carries the request address with bits 4, 1 and 0 cleared. `fill_rsp_data[31:0]` is the word with bit 4 clear and `[63:32]` is the word with bit 4 set. The response, with code 2'b10, follows one cycle after `fill_rsp_valid`.
- R5: The local module is direct-mapped with tag `addr[31:11]`. A refill replaces the whole set, so a later access under the evicted tag misses.
- R6: A store that hits locally updates that word only and responds one cycle later with code 2'b00. A store that misses locally refills the subblock, merges the store word in, and responds with code 2'b10. Every store response carries data 0.
- R7: A remote load that misses the side buffer pulses `rem_req_valid` with `rem_req_we`=0 one cycle after acceptance. The pulse carries the address with bits 4, 1 and 0 cleared. The response, with code 2'b10 and the selected word of `rem_rsp_data` (same word order as R4), follows one cycle after `rem_rsp_valid`.
- R8: A remote read response is stored in the side buffer. Later loads to either word of that subblock respond in one cycle with code 2'b01 and issue no remote request.
- R9: The side buffer has 4 entries filled in round-robin order. The fifth distinct remote subblock replaces the first one filled, and the other three entries stay.
- R10: A remote store responds one cycle later with code 2'b10 and data 0. It pulses `rem_req_valid` with `rem_req_we`=1, the word address (bits 1:0 cleared) and the data. It invalidates only a matching buffer entry.
- R11: While a refill or remote read is outstanding, `req_ready` is 0 and requests presented on the port are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Slice can accept a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 2 | Outcome: 00 local hit, 01 buffer hit, 10 remote or miss |
| rsp_data | output | 32 | Load data, 0 for stores |
| rem_req_valid | output | 1 | Remote access pulse |
| rem_req_we | output | 1 | Remote access is a store |
| rem_req_addr | output | 32 | Remote subblock or word address |
| rem_req_wdata | output | 32 | Remote store data |
| rem_rsp_valid | input | 1 | Remote subblock returned |
| rem_rsp_data | input | 64 | Remote subblock, lower word first |
| fill_req_valid | output | 1 | Local refill pulse |
| fill_req_addr | output | 32 | Local subblock address |
| fill_rsp_valid | input | 1 | Refill data returned |
| fill_rsp_data | input | 64 | Refill subblock, lower word first |

## Verification
The hardest state to reach from the ports is a full side buffer with the replacement pointer wrapped. In that state a single eviction must remove exactly the oldest subblock, and a remote store must then remove one specific entry without disturbing its neighbours. The bench gets there by issuing five remote misses to distinct subblocks spread over the three foreign home clusters. It then probes each surviving entry for a one-cycle buffer hit before it reloads the evicted one. It then stores to a still-buffered word and reads it back through a second remote trip. Every set of the local module is also swept with a miss followed by hits on both words.

// File: rtl/ilc_pkg.sv
package ilc_pkg;

  typedef enum logic [1:0] {
    CODE_LOCAL = 2'b00,
    CODE_ABUF  = 2'b01,
    CODE_FAR   = 2'b10
  } rsp_code_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WREM  = 2'b01,
    ST_WFILL = 2'b10
  } ctl_state_e;

endpackage

// File: rtl/ilc_local_module.sv
module ilc_local_module #(
  parameter int SETS   = 64,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 21,
  parameter int LINE_W = 64,
  parameter int DATA_W = 32,
  parameter int SUB_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [LINE_W-1:0] lk_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SUB_W-1:0]  wr_sub,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line
);

  logic [SETS-1:0]   valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_line = line_q[lk_idx];

  always_comb begin
    valid_d = valid_q;
    if (fill_en) valid_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= '0;
    else if (fill_en) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= fill_tag;
      line_q[fill_idx] <= fill_line;
    end else if (wr_en) begin
      line_q[wr_idx][int'(wr_sub)*DATA_W +: DATA_W] <= wr_word;
    end
  end

  AST_LM_WRITE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> valid_q[wr_idx]); // R6
  AST_LM_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && fill_en)); // R4

endmodule

// File: rtl/ilc_attract_buf.sv
module ilc_attract_buf #(
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2,
  parameter int KEY_W  = 29,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  lk_key,
  output logic              lk_hit,
  output logic [LINE_W-1:0] lk_line,
  input  logic              fill_en,
  input  logic [KEY_W-1:0]  fill_key,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              inv_en,
  input  logic [KEY_W-1:0]  inv_key
);

  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [DEPTH-1:0]  hit_vec, inv_vec;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [KEY_W-1:0]  key_q  [DEPTH];
  logic [LINE_W-1:0] line_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (key_q[g] == lk_key);
    assign inv_vec[g] = vld_q[g] && (key_q[g] == inv_key);
  end

  assign lk_hit = |hit_vec;

  always_comb begin
    lk_line = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) lk_line = lk_line | line_q[i];
    end
  end

  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (inv_en) vld_d = vld_d & ~inv_vec;
    if (fill_en) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d        = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (fill_en || inv_en) begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      key_q[ptr_q]  <= fill_key;
      line_q[ptr_q] <= fill_line;
    end
  end

  AST_AB_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R8
  AST_AB_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1))); // R9
  AST_AB_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !fill_en) |=> ((vld_q & $past(inv_vec)) == '0)); // R10

endmodule

// File: rtl/ilc_slice.sv
module ilc_slice
  import ilc_pkg::*;
#(
  parameter int CLUSTER_ID = 0,
  parameter int N_CLUST    = 4,
  parameter int BLK_WORDS  = 8,
  parameter int SETS       = 64,
  parameter int AB_DEPTH   = 4,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_we,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic                            rsp_valid,
  output logic [1:0]                      rsp_code,
  output logic [DATA_W-1:0]               rsp_data,
  output logic                            rem_req_valid,
  output logic                            rem_req_we,
  output logic [ADDR_W-1:0]               rem_req_addr,
  output logic [DATA_W-1:0]               rem_req_wdata,
  input  logic                            rem_rsp_valid,
  input  logic [(BLK_WORDS/N_CLUST)*DATA_W-1:0] rem_rsp_data,
  output logic                            fill_req_valid,
  output logic [ADDR_W-1:0]               fill_req_addr,
  input  logic                            fill_rsp_valid,
  input  logic [(BLK_WORDS/N_CLUST)*DATA_W-1:0] fill_rsp_data
);

  localparam int OFF_W    = $clog2(DATA_W / 8);
  localparam int HOME_W   = $clog2(N_CLUST);
  localparam int SUB_N    = BLK_WORDS / N_CLUST;
  localparam int SUB_W    = $clog2(SUB_N);
  localparam int IDX_W    = $clog2(SETS);
  localparam int HOME_LSB = OFF_W;
  localparam int SUB_LSB  = OFF_W + HOME_W;
  localparam int IDX_LSB  = SUB_LSB + SUB_W;
  localparam int TAG_LSB  = IDX_LSB + IDX_W;
  localparam int TAG_W    = ADDR_W - TAG_LSB;
  localparam int KEY_W    = ADDR_W - IDX_LSB + HOME_W;
  localparam int LINE_W   = SUB_N * DATA_W;
  localparam int PTR_W    = $clog2(AB_DEPTH);
  localparam logic [HOME_W-1:0] MY_HOME = HOME_W'(CLUSTER_ID);

  // request decode
  logic [HOME_W-1:0] r_home;
  logic [SUB_W-1:0]  r_sub;
  logic [IDX_W-1:0]  r_idx;
  logic [TAG_W-1:0]  r_tag;
  logic [KEY_W-1:0]  r_key;
  logic              r_local;
  logic [ADDR_W-1:0] r_sub_addr, r_word_addr;

  assign r_home  = req_addr[HOME_LSB +: HOME_W];
  assign r_sub   = req_addr[SUB_LSB +: SUB_W];
  assign r_idx   = req_addr[IDX_LSB +: IDX_W];
  assign r_tag   = req_addr[TAG_LSB +: TAG_W];
  assign r_key   = {req_addr[ADDR_W-1:IDX_LSB], r_home};
  assign r_local = (r_home == MY_HOME);

  always_comb begin
    r_word_addr = req_addr;
    r_word_addr[OFF_W-1:0] = '0;
    r_sub_addr = r_word_addr;
    r_sub_addr[SUB_LSB +: SUB_W] = '0;
  end

  // state
  ctl_state_e        state_q, state_d;
  logic              pend_en;
  logic              pend_we_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_wdata_q;
  logic [SUB_W-1:0]  p_sub;
  logic [IDX_W-1:0]  p_idx;
  logic [TAG_W-1:0]  p_tag;
  logic [KEY_W-1:0]  p_key;

  assign p_sub = pend_addr_q[SUB_LSB +: SUB_W];
  assign p_idx = pend_addr_q[IDX_LSB +: IDX_W];
  assign p_tag = pend_addr_q[TAG_LSB +: TAG_W];
  assign p_key = {pend_addr_q[ADDR_W-1:IDX_LSB], pend_addr_q[HOME_LSB +: HOME_W]};

  // outgoing next values
  logic              rsp_valid_d, rem_valid_d, rem_we_d, fill_valid_d;
  logic [1:0]        rsp_code_d;
  logic [DATA_W-1:0] rsp_data_d, rem_wdata_d;
  logic [ADDR_W-1:0] rem_addr_d, fill_addr_d;
  logic              rsp_valid_q, rem_valid_q, rem_we_q, fill_valid_q;
  logic [1:0]        rsp_code_q;
  logic [DATA_W-1:0] rsp_data_q, rem_wdata_q;
  logic [ADDR_W-1:0] rem_addr_q, fill_addr_q;

  // submodule hookup
  logic              lm_hit, lm_wr_en, lm_fill_en;
  logic [LINE_W-1:0] lm_line, merged_line;
  logic              ab_hit, ab_fill_en, ab_inv_en;
  logic [LINE_W-1:0] ab_line;
  logic              accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  ilc_local_module #(
    .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .LINE_W(LINE_W), .DATA_W(DATA_W), .SUB_W(SUB_W)
  ) u_lm (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(r_idx), .lk_tag(r_tag), .lk_hit(lm_hit), .lk_line(lm_line),
    .wr_en(lm_wr_en), .wr_idx(r_idx), .wr_sub(r_sub), .wr_word(req_wdata),
    .fill_en(lm_fill_en), .fill_idx(p_idx), .fill_tag(p_tag), .fill_line(merged_line)
  );

  ilc_attract_buf #(
    .DEPTH(AB_DEPTH), .PTR_W(PTR_W), .KEY_W(KEY_W), .LINE_W(LINE_W)
  ) u_ab (
    .clk(clk), .rst_n(rst_n),
    .lk_key(r_key), .lk_hit(ab_hit), .lk_line(ab_line),
    .fill_en(ab_fill_en), .fill_key(p_key), .fill_line(rem_rsp_data),
    .inv_en(ab_inv_en), .inv_key(r_key)
  );

  always_comb begin
    merged_line = fill_rsp_data;
    if (pend_we_q) merged_line[int'(p_sub)*DATA_W +: DATA_W] = pend_wdata_q;
  end

  // next-state process
  always_comb begin
    state_d      = state_q;
    pend_en      = 1'b0;
    lm_wr_en     = 1'b0;
    lm_fill_en   = 1'b0;
    ab_fill_en   = 1'b0;
    ab_inv_en    = 1'b0;
    rsp_valid_d  = 1'b0;
    rsp_code_d   = CODE_FAR;
    rsp_data_d   = '0;
    rem_valid_d  = 1'b0;
    rem_we_d     = 1'b0;
    rem_addr_d   = r_sub_addr;
    rem_wdata_d  = req_wdata;
    fill_valid_d = 1'b0;
    fill_addr_d  = r_sub_addr;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (r_local) begin
            if (lm_hit) begin
              lm_wr_en    = req_we;
              rsp_valid_d = 1'b1;
              rsp_code_d  = CODE_LOCAL;
              rsp_data_d  = req_we ? '0 : lm_line[int'(r_sub)*DATA_W +: DATA_W];
            end else begin
              pend_en      = 1'b1;
              fill_valid_d = 1'b1;
              state_d      = ST_WFILL;
            end
          end else if (req_we) begin
            ab_inv_en   = 1'b1;
            rem_valid_d = 1'b1;
            rem_we_d    = 1'b1;
            rem_addr_d  = r_word_addr;
            rsp_valid_d = 1'b1;
          end else if (ab_hit) begin
            rsp_valid_d = 1'b1;
            rsp_code_d  = CODE_ABUF;
            rsp_data_d  = ab_line[int'(r_sub)*DATA_W +: DATA_W];
          end else begin
            pend_en     = 1'b1;
            rem_valid_d = 1'b1;
            state_d     = ST_WREM;
          end
        end
      end
      ST_WREM: begin
        if (rem_rsp_valid) begin
          ab_fill_en  = 1'b1;
          rsp_valid_d = 1'b1;
          rsp_data_d  = rem_rsp_data[int'(p_sub)*DATA_W +: DATA_W];
          state_d     = ST_IDLE;
        end
      end
      ST_WFILL: begin
        if (fill_rsp_valid) begin
          lm_fill_en  = 1'b1;
          rsp_valid_d = 1'b1;
          rsp_data_d  = pend_we_q ? '0 : fill_rsp_data[int'(p_sub)*DATA_W +: DATA_W];
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      rsp_valid_q  <= 1'b0;
      rem_valid_q  <= 1'b0;
      fill_valid_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      rsp_valid_q  <= rsp_valid_d;
      rem_valid_q  <= rem_valid_d;
      fill_valid_q <= fill_valid_d;
    end
  end

  // data registers, enabled
  always_ff @(posedge clk) begin
    if (pend_en) begin
      pend_we_q    <= req_we;
      pend_addr_q  <= req_addr;
      pend_wdata_q <= req_wdata;
    end
    if (rsp_valid_d) begin
      rsp_code_q <= rsp_code_d;
      rsp_data_q <= rsp_data_d;
    end
    if (rem_valid_d) begin
      rem_we_q    <= rem_we_d;
      rem_addr_q  <= rem_addr_d;
      rem_wdata_q <= rem_wdata_d;
    end
    if (fill_valid_d) fill_addr_q <= fill_addr_d;
  end

  assign rsp_valid      = rsp_valid_q;
  assign rsp_code       = rsp_code_q;
  assign rsp_data       = rsp_data_q;
  assign rem_req_valid  = rem_valid_q;
  assign rem_req_we     = rem_we_q;
  assign rem_req_addr   = rem_addr_q;
  assign rem_req_wdata  = rem_wdata_q;
  assign fill_req_valid = fill_valid_q;
  assign fill_req_addr  = fill_addr_q;

  AST_REM_NOT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    rem_req_valid |-> (rem_req_addr[HOME_LSB +: HOME_W] != MY_HOME)); // R2
  AST_FILL_IS_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> (fill_req_addr[HOME_LSB +: HOME_W] == MY_HOME)); // R4
  AST_LOCAL_HIT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && r_local && lm_hit && !req_we) |=> (rsp_valid && rsp_code == CODE_LOCAL)); // R3
  AST_REM_LOAD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_req_valid && !rem_req_we) |-> !req_ready); // R11
  AST_REM_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_rsp_valid && state_q == ST_WREM) |=> (rsp_valid && rsp_code == CODE_FAR)); // R7
  AST_ABUF_NO_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !r_local && !req_we && ab_hit) |=> (!rem_req_valid && rsp_code == CODE_ABUF)); // R8

endmodule

// File: tb/ilc_slice_tb.sv
`timescale 1ns/1ps
module ilc_slice_tb;

  localparam real CLK_HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we;
  logic [31:0] req_addr, req_wdata;
  logic        req_ready;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_data;
  logic        rem_req_valid, rem_req_we;
  logic [31:0] rem_req_addr, rem_req_wdata;
  logic        rem_rsp_valid;
  logic [63:0] rem_rsp_data;
  logic        fill_req_valid;
  logic [31:0] fill_req_addr;
  logic        fill_rsp_valid;
  logic [63:0] fill_rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  int n_rem = 0;
  int n_fill = 0;
  logic [31:0] last_rem_addr, last_rem_wdata, last_fill_addr;
  logic        last_rem_we;
  logic [31:0] far_mem [logic [31:0]];

  always #(CLK_HALF) clk = ~clk;

  ilc_slice u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
    .rem_req_valid(rem_req_valid), .rem_req_we(rem_req_we),
    .rem_req_addr(rem_req_addr), .rem_req_wdata(rem_req_wdata),
    .rem_rsp_valid(rem_rsp_valid), .rem_rsp_data(rem_rsp_data),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data)
  );

  function automatic logic [31:0] mk(input logic [20:0] tag, input logic [5:0] idx,
                                     input logic sub, input logic [1:0] home);
    return {tag, idx, sub, home, 2'b00};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (far_mem.exists(a)) return far_mem[a];
    return (a * 32'h0000_9E37) ^ 32'hC3C3_0000;
  endfunction

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // refill responder
  initial begin
    fill_rsp_valid = 1'b0;
    fill_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (fill_req_valid) begin
        logic [31:0] a;
        a = fill_req_addr;
        n_fill++;
        last_fill_addr = a;
        repeat (2) @(negedge clk);
        fill_rsp_data  = {mem_word(a | 32'h10), mem_word(a)};
        fill_rsp_valid = 1'b1;
        @(negedge clk);
        fill_rsp_valid = 1'b0;
      end
    end
  end

  // remote responder
  initial begin
    rem_rsp_valid = 1'b0;
    rem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rem_req_valid) begin
        logic [31:0] a;
        a = rem_req_addr;
        n_rem++;
        last_rem_addr  = a;
        last_rem_we    = rem_req_we;
        last_rem_wdata = rem_req_wdata;
        if (rem_req_we) begin
          far_mem[a] = rem_req_wdata;
        end else begin
          repeat (3) @(negedge clk);
          rem_rsp_data  = {mem_word(a | 32'h10), mem_word(a)};
          rem_rsp_valid = 1'b1;
          @(negedge clk);
          rem_rsp_valid = 1'b0;
        end
      end
    end
  end

  task automatic acc(input string rq, input logic we, input logic [31:0] a,
                     input logic [31:0] wd, input logic [1:0] ecode,
                     input logic [31:0] edata);
    int lat;
    logic fast;
    @(negedge clk);
    req_we = we; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    fast = (ecode != 2'b10) || (we && a[3:2] != 2'b00);
    check(rq, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check(rq, "code", {30'd0, rsp_code}, {30'd0, ecode});
    check(rq, "data", rsp_data, edata);
    check(rq, "one-cycle", {31'd0, lat == 1}, {31'd0, fast});
  endtask

  initial begin
    #(CLK_HALF * 2 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [20:0] T, T2, T3, TA, TB, TC;
    int f0, r0;
    T = 21'h0A5; T2 = 21'h133; T3 = 21'h07E;
    TA = 21'h011; TB = 21'h022; TC = 21'h033;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "req_ready", {31'd0, req_ready}, 32'd1);
    check("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1", "rem_req_valid", {31'd0, rem_req_valid}, 32'd0);
    check("R1", "fill_req_valid", {31'd0, fill_req_valid}, 32'd0);

    // R2 R3 R4 sweep of every set: miss then hit both words
    for (int s = 0; s < 64; s++) begin
      f0 = n_fill;
      acc("R4", 1'b0, mk(T, 6'(s), 1'b0, 2'd0), 0, 2'b10, mem_word(mk(T, 6'(s), 1'b0, 2'd0)));
      check("R4", "fill count", n_fill - f0, 1);
      check("R4", "fill addr", last_fill_addr, mk(T, 6'(s), 1'b0, 2'd0));
      acc("R3", 1'b0, mk(T, 6'(s), 1'b1, 2'd0), 0, 2'b00, mem_word(mk(T, 6'(s), 1'b1, 2'd0)));
      acc("R2", 1'b0, mk(T, 6'(s), 1'b0, 2'd0) | 32'h3, 0, 2'b00, mem_word(mk(T, 6'(s), 1'b0, 2'd0)));
    end
    check("R2", "no remote for home", n_rem, 0);

    // R5 conflict in a direct-mapped set
    acc("R5", 1'b0, mk(T3, 6'd10, 1'b0, 2'd0), 0, 2'b10, mem_word(mk(T3, 6'd10, 1'b0, 2'd0)));
    acc("R5", 1'b0, mk(T, 6'd10, 1'b1, 2'd0), 0, 2'b10, mem_word(mk(T, 6'd10, 1'b1, 2'd0)));
    acc("R5", 1'b0, mk(T, 6'd10, 1'b0, 2'd0), 0, 2'b00, mem_word(mk(T, 6'd10, 1'b0, 2'd0)));

    // R6 stores
    acc("R6", 1'b1, mk(T, 6'd3, 1'b1, 2'd0), 32'hDEAD_0001, 2'b00, 0);
    acc("R6", 1'b0, mk(T, 6'd3, 1'b1, 2'd0), 0, 2'b00, 32'hDEAD_0001);
    acc("R6", 1'b0, mk(T, 6'd3, 1'b0, 2'd0), 0, 2'b00, mem_word(mk(T, 6'd3, 1'b0, 2'd0)));
    acc("R6", 1'b1, mk(T2, 6'd40, 1'b0, 2'd0), 32'hBEEF_0002, 2'b10, 0);
    acc("R6", 1'b0, mk(T2, 6'd40, 1'b0, 2'd0), 0, 2'b00, 32'hBEEF_0002);
    acc("R6", 1'b0, mk(T2, 6'd40, 1'b1, 2'd0), 0, 2'b00, mem_word(mk(T2, 6'd40, 1'b1, 2'd0)));

    // R7 R8 remote misses then buffer hits, homes 1..3
    for (int h = 1; h < 4; h++) begin
      r0 = n_rem;
      acc("R7", 1'b0, mk(TA, 6'd5, 1'b1, 2'(h)), 0, 2'b10, mem_word(mk(TA, 6'd5, 1'b1, 2'(h))));
      check("R7", "rem addr", last_rem_addr, mk(TA, 6'd5, 1'b0, 2'(h)));
      check("R7", "rem we", {31'd0, last_rem_we}, 32'd0);
      acc("R8", 1'b0, mk(TA, 6'd5, 1'b0, 2'(h)), 0, 2'b01, mem_word(mk(TA, 6'd5, 1'b0, 2'(h))));
      acc("R8", 1'b0, mk(TA, 6'd5, 1'b1, 2'(h)), 0, 2'b01, mem_word(mk(TA, 6'd5, 1'b1, 2'(h))));
      check("R8", "rem count", n_rem - r0, 1);
    end

    // R9 fill fourth entry, then fifth evicts the first
    acc("R9", 1'b0, mk(TB, 6'd5, 1'b0, 2'd1), 0, 2'b10, mem_word(mk(TB, 6'd5, 1'b0, 2'd1)));
    acc("R9", 1'b0, mk(TC, 6'd5, 1'b0, 2'd2), 0, 2'b10, mem_word(mk(TC, 6'd5, 1'b0, 2'd2)));
    acc("R9", 1'b0, mk(TA, 6'd5, 1'b0, 2'd2), 0, 2'b01, mem_word(mk(TA, 6'd5, 1'b0, 2'd2)));
    acc("R9", 1'b0, mk(TA, 6'd5, 1'b1, 2'd3), 0, 2'b01, mem_word(mk(TA, 6'd5, 1'b1, 2'd3)));
    acc("R9", 1'b0, mk(TB, 6'd5, 1'b1, 2'd1), 0, 2'b01, mem_word(mk(TB, 6'd5, 1'b1, 2'd1)));
    acc("R9", 1'b0, mk(TC, 6'd5, 1'b1, 2'd2), 0, 2'b01, mem_word(mk(TC, 6'd5, 1'b1, 2'd2)));
    acc("R9", 1'b0, mk(TA, 6'd5, 1'b0, 2'd1), 0, 2'b10, mem_word(mk(TA, 6'd5, 1'b0, 2'd1)));

    // R10 remote store to a buffered word
    r0 = n_rem;
    acc("R10", 1'b1, mk(TA, 6'd5, 1'b0, 2'd3) | 32'h2, 32'hCAFE_0003, 2'b10, 0);
    check("R10", "rem count", n_rem - r0, 1);
    check("R10", "rem we", {31'd0, last_rem_we}, 32'd1);
    check("R10", "rem addr", last_rem_addr, mk(TA, 6'd5, 1'b0, 2'd3));
    check("R10", "rem wdata", last_rem_wdata, 32'hCAFE_0003);
    acc("R10", 1'b0, mk(TB, 6'd5, 1'b0, 2'd1), 0, 2'b01, mem_word(mk(TB, 6'd5, 1'b0, 2'd1)));
    acc("R10", 1'b0, mk(TA, 6'd5, 1'b0, 2'd3), 0, 2'b10, 32'hCAFE_0003);

    // R11 requests ignored while a remote read is outstanding
    f0 = n_fill;
    @(negedge clk);
    req_we = 1'b0; req_addr = mk(TC, 6'd9, 1'b0, 2'd3); req_valid = 1'b1;
    @(negedge clk);
    req_addr = mk(T3, 6'd20, 1'b0, 2'd0);
    check("R11", "req_ready busy", {31'd0, req_ready}, 32'd0);
    while (!rsp_valid) @(negedge clk);
    req_valid = 1'b0;
    check("R11", "code", {30'd0, rsp_code}, 32'd2);
    check("R11", "data", rsp_data, mem_word(mk(TC, 6'd9, 1'b0, 2'd3)));
    @(negedge clk);
    check("R11", "no extra rsp", {31'd0, rsp_valid}, 32'd0);
    repeat (6) @(negedge clk);
    check("R11", "no fill", n_fill - f0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule